// File: doc/BRIEF.md
# Presettable Binary Counter with Carry Output

This block is a synchronous up-counter of parameterised width (4 bits by default). On a rising clock edge it can be parallel-loaded from a data input, advanced by one, or held. Two count-enable inputs gate the advance. Only one of them, `en_t`, also gates the terminal-count output `carry`. Because of this split, several stages can be chained into a wider counter. Each stage's `carry` drives the next stage's `en_t`, and `en_p` is shared by all stages as a common run/stop control.

The clear input is active low. A parameter selects how it acts. In asynchronous mode it empties the counter at once. In synchronous mode it acts at the next rising edge. Synchronous mode lets an external decode of one chosen count drive the clear, which gives a glitch-free counter of any modulus, such as modulo-11.

Top module: `bin_preset_counter`

## Requirements
- R1: While `clr_n` is low, the count becomes zero. With `ASYNC_CLEAR=1` this happens immediately, without a clock edge. With `ASYNC_CLEAR=0` it happens at the next rising edge, and the count keeps its value until then.
- R2: Clear takes priority over load. If `clr_n` and `ld_n` are both low at an edge, the count is zero after that edge.
- R3: If `ld_n` is low at a rising edge, `q` takes the value of `din`, whatever the state of the enables. No increment happens in that cycle.
- R4: At a rising edge, the count increases by one only when `ld_n`, `en_p` and `en_t` are all high. Otherwise it keeps its value.
- R5: `carry` is high exactly when `en_t` is high and `q` is all ones for the configured width. It does not depend on `en_p` or `ld_n`.
- R6: Counting from the all-ones value gives zero at the next edge.
- R7: Three 4-bit stages form a 12-bit synchronous counter when each stage's `carry` feeds the next stage's `en_t` and all stages share clock, `en_p`, `ld_n` and clear. The chain loads 12-bit values and wraps from 0xFFF to 0x000.
- R8: In synchronous mode, driving `clr_n` low when the count equals 10 gives a repeating sequence of 0 through 10.
- R9: The following sequence is reproduced: clear to 0, load 12, count 13, 14, 15, 0, 1, 2, then drop `en_p` and hold at 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Active-low clear; asynchronous or synchronous by parameter |
| ld_n | input | 1 | Active-low parallel load |
| din | input | WIDTH | Parallel load value, bit 0 least significant |
| en_p | input | 1 | Count enable that does not affect `carry` |
| en_t | input | 1 | Count enable that also gates `carry` |
| q | output | WIDTH | Current count, bit 0 least significant |
| carry | output | 1 | High when `en_t` is high and `q` is all ones |

## Verification
A table of input vectors runs the reference sequence on an asynchronous instance and a synchronous instance side by side. It includes clear and load together, a load with both enables low, and a load during active enables. It also checks `carry` at all ones with each enable dropped in turn, which separates the gating of `carry` by `en_t` from the count enable. A clear pulse placed mid-cycle separates the two clear modes: the asynchronous instance must read zero before the edge, and the synchronous instance must keep its value until the edge. A three-stage chain counts through several hundred values and crosses the 0xFFF wrap, which shows that carry propagates across stages. A decoded-clear instance checks the modulo-11 sequence for wrong or early wraps.

// File: rtl/bin_preset_counter.sv
module bin_preset_counter #(
  parameter int WIDTH       = 4,
  parameter bit ASYNC_CLEAR = 1'b1
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             ld_n,
  input  logic [WIDTH-1:0] din,
  input  logic             en_p,
  input  logic             en_t,
  output logic [WIDTH-1:0] q,
  output logic             carry
);
  localparam logic [WIDTH-1:0] ALL_ONES = '1;
  localparam logic [WIDTH-1:0] ONE      = WIDTH'(1);

  logic [WIDTH-1:0] cnt;
  logic [WIDTH-1:0] nxt;

  always_comb begin
    if (!ld_n)              nxt = din;
    else if (en_p && en_t)  nxt = cnt + ONE;
    else                    nxt = cnt;
  end

  generate
    if (ASYNC_CLEAR) begin : g_async
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) cnt <= '0;
        else        cnt <= nxt;
      end
    end else begin : g_sync
      always_ff @(posedge clk) begin
        if (!clr_n) cnt <= '0;
        else        cnt <= nxt;
      end
    end
  endgenerate

  assign q     = cnt;
  assign carry = en_t && (cnt == ALL_ONES);
endmodule

module bin_preset_counter_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             clr_n,
  input logic             ld_n,
  input logic [WIDTH-1:0] din,
  input logic             en_p,
  input logic             en_t,
  input logic [WIDTH-1:0] q,
  input logic             carry
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  a_r3_load: assert property (@(posedge clk) disable iff (!clr_n)
    !ld_n |=> q == $past(din));

  a_r4_count: assert property (@(posedge clk) disable iff (!clr_n)
    (ld_n && en_p && en_t) |=> q == $past(q) + ONE);

  a_r4_hold: assert property (@(posedge clk) disable iff (!clr_n)
    (ld_n && !(en_p && en_t)) |=> $stable(q));

  a_r5_gate: assert property (@(posedge clk) disable iff (!clr_n)
    !en_t |-> !carry);

  a_r6_wrap: assert property (@(posedge clk) disable iff (!clr_n)
    (ld_n && en_p && carry) |=> q == '0);
endmodule

bind bin_preset_counter bin_preset_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .din(din),
  .en_p(en_p), .en_t(en_t), .q(q), .carry(carry)
);

// File: tb/bin_preset_counter_bench.sv
module bin_preset_counter_bench;
  localparam int PERIOD = 10;
  localparam int NVEC   = 16;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  logic clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  // shared stimulus for async (a) and sync (s) instances
  logic       clr_n = 1'b0, ld_n = 1'b1, en_p = 1'b0, en_t = 1'b0;
  logic [3:0] din = '0;
  logic [3:0] qa, qs;
  logic       ca, cs;

  bin_preset_counter #(.WIDTH(4), .ASYNC_CLEAR(1'b1)) u_bin_preset_counter (
    .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .din(din),
    .en_p(en_p), .en_t(en_t), .q(qa), .carry(ca));
  bin_preset_counter #(.WIDTH(4), .ASYNC_CLEAR(1'b0)) u_sync (
    .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .din(din),
    .en_p(en_p), .en_t(en_t), .q(qs), .carry(cs));

  // three-stage chain
  logic        k_clr_n = 1'b0, k_ld_n = 1'b1, k_en_p = 1'b0;
  logic [11:0] k_din = '0;
  logic [11:0] k_q;
  logic [2:0]  k_c;
  for (genvar g = 0; g < 3; g++) begin : g_chain
    logic t_in;
    if (g == 0) begin : g_first
      assign t_in = 1'b1;
    end else begin : g_next
      assign t_in = k_c[g-1];
    end
    bin_preset_counter #(.WIDTH(4), .ASYNC_CLEAR(1'b0)) u_stage (
      .clk(clk), .clr_n(k_clr_n), .ld_n(k_ld_n), .din(k_din[4*g +: 4]),
      .en_p(k_en_p), .en_t(t_in), .q(k_q[4*g +: 4]), .carry(k_c[g]));
  end

  // modulo-11 via decoded synchronous clear
  logic       m_rst_n = 1'b0;
  logic [3:0] m_q;
  logic       m_c;
  logic       m_clr_n;
  assign m_clr_n = m_rst_n && (m_q != 4'd10);
  bin_preset_counter #(.WIDTH(4), .ASYNC_CLEAR(1'b0)) u_mod11 (
    .clk(clk), .clr_n(m_clr_n), .ld_n(1'b1), .din(4'd0),
    .en_p(1'b1), .en_t(1'b1), .q(m_q), .carry(m_c));

  // {clr_n, ld_n, en_p, en_t, din[3:0], exp_q[3:0], exp_carry}
  localparam logic [12:0] VEC [NVEC] = '{
    {4'b0111, 4'd5,  4'd0,  1'b0},  // R1 clear
    {4'b0011, 4'd9,  4'd0,  1'b0},  // R2 clear beats load
    {4'b1011, 4'd12, 4'd12, 1'b0},  // R9 load 12 (R3)
    {4'b1111, 4'd0,  4'd13, 1'b0},  // R9 13
    {4'b1111, 4'd0,  4'd14, 1'b0},  // R9 14
    {4'b1111, 4'd0,  4'd15, 1'b1},  // R9 15, R5 carry
    {4'b1111, 4'd0,  4'd0,  1'b0},  // R6 wrap
    {4'b1111, 4'd0,  4'd1,  1'b0},  // R9 1
    {4'b1111, 4'd0,  4'd2,  1'b0},  // R9 2
    {4'b1101, 4'd0,  4'd2,  1'b0},  // R9 hold, R4
    {4'b1011, 4'd15, 4'd15, 1'b1},  // R3 load 15
    {4'b1110, 4'd0,  4'd15, 1'b0},  // R5 en_t low gates carry, R4 hold
    {4'b1101, 4'd0,  4'd15, 1'b1},  // R5 carry ignores en_p
    {4'b1000, 4'd3,  4'd3,  1'b0},  // R3 load with enables low
    {4'b1011, 4'd7,  4'd7,  1'b0},  // R3 load inhibits count
    {4'b1111, 4'd0,  4'd8,  1'b0}   // R4 count
  };

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // table walk
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      {clr_n, ld_n, en_p, en_t, din} = VEC[i][12:5];
      @(posedge clk); #1;
      check("R9 table async q", qa, VEC[i][4:1]);
      check("R9 table sync q",  qs, VEC[i][4:1]);
      check("R5 table async carry", ca, VEC[i][0]);
      check("R5 table sync carry",  cs, VEC[i][0]);
    end
    // R1: mid-cycle clear, async clears at once, sync waits for edge
    @(negedge clk);
    en_p = 1'b0; en_t = 1'b0;
    #1 clr_n = 1'b0;
    #1;
    check("R1 async immediate", qa, 0);
    check("R1 sync waits", qs, 8);
    @(posedge clk); #1;
    check("R1 sync at edge", qs, 0);
    @(negedge clk);
    clr_n = 1'b1;

    // R7 chain
    @(negedge clk);
    k_en_p = 1'b1; k_clr_n = 1'b1;
    for (int k = 1; k <= 300; k++) begin
      @(posedge clk); #1;
      check("R7 chain count", k_q, k);
    end
    @(negedge clk);
    k_ld_n = 1'b0; k_din = 12'hFFE;
    @(posedge clk); #1;
    check("R7 chain load", k_q, 12'hFFE);
    @(negedge clk);
    k_ld_n = 1'b1;
    @(posedge clk); #1;
    check("R7 chain at max", k_q, 12'hFFF);
    check("R7 chain top carry", k_c[2], 1);
    @(posedge clk); #1;
    check("R7 chain wrap", k_q, 0);
    check("R7 chain carry clear", k_c[2], 0);
    @(negedge clk);
    k_en_p = 1'b0;
    @(posedge clk); #1;
    check("R7 chain hold", k_q, 0);

    // R8 modulo-11
    @(negedge clk);
    m_rst_n = 1'b1;
    for (int k = 1; k <= 30; k++) begin
      @(posedge clk); #1;
      check("R8 mod11 count", m_q, k % 11);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule